// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps the wall-clock time and date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. They live in a small indexed register file next to two control registers. A one-hertz tick input advances the time by one second. Software reaches the registers in two steps. It first loads a register index. Then it reads the data for that index, or writes data to it.

The stored format can be changed at run time. One control bit selects binary or BCD storage. Another selects 24-hour or 12-hour hours, where bit 7 of the hour byte marks PM. Changing either bit leaves the stored bytes as they are. A set bit freezes all advancing while software loads a new time.

Each tick opens an update window of a fixed number of clock cycles. An update-in-progress flag is high during that window. The time registers all change together on the last edge of the window. Reads taken while the flag is low therefore see a consistent snapshot.

Top module: `tod_calendar`

## Requirements
- R1: The index is loaded by `idx_we` and used from the next cycle. `rd_data` is registered and shows, one cycle later, the register selected by the index. Time fields sit at seconds 0x0, minutes 0x2, hours 0x4, day of week 0x6, day of month 0x7, month 0x8 and year 0x9. Control A is at 0xA and control B at 0xB. Every other index reads 0x00, and writes to it are dropped.
- R2: Seconds and minutes count 0 to 59. Going from 59 to 0 carries into the next field.
- R3: In 24-hour mode the hour counts 0 to 23. Going from 23 to 0 advances the day fields.
- R4: In 12-hour mode the hour byte holds 1 to 12 in bits 6:0, and bit 7 set means PM. 11 AM rolls to 12 PM (0x92 in BCD), 12 PM rolls to 1 PM (0x81), and 11 PM rolls to 12 AM (0x12) with a day carry. 12 AM rolls to 1 AM.
- R5: Day of week counts 1 to 7 and wraps from 7 to 1 on each day carry.
- R6: The day of month wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year value is divisible by 4 and 28 otherwise. All other months have 31 days.
- R7: Month counts 1 to 12. Going from 12 to 1 carries into the year, which wraps from 99 to 0.
- R8: Bit 2 of control B selects binary storage when 1 and BCD storage when 0. Bit 1 selects 24-hour mode when 1 and 12-hour mode when 0.
- R9: While bit 7 of control B is 1, ticks are ignored. The time is not advanced and `uip` stays low.
- R10: `uip` goes high on the edge after a tick is sampled and stays high for `UIP_CYC` cycles. The time fields change on the edge that ends the window. Bit 7 of control A reads as `uip`, and writes to that bit are ignored.
- R11: A change of the format bits does not convert the stored time bytes.
- R12: After reset the time is 00:00:00, day of week 1, day 1, month 1, year 0. Control A is 0x00, control B is 0x02 (BCD, 24-hour), and `rd_data` and `uip` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second advance request, one cycle wide |
| idx_we | input | 1 | Load the register index |
| idx_in | input | IDX_W | New register index |
| dat_we | input | 1 | Write `dat_in` to the indexed register |
| dat_in | input | 8 | Write data |
| rd_data | output | 8 | Registered read data of the indexed register |
| uip | output | 1 | Update in progress |

## Verification
A wrong carry or a wrong month length stays hidden until the time crosses that boundary. So the bench loads each roll-over boundary directly under the set bit, lets one tick through, and reads every field back within a few cycles of the window closing. A timing fault in the update window shows up on the first tick as a `uip` pulse of the wrong length, and the per-cycle comparison against the model catches it at once. A format-decoding error shows up as a wrong byte code on the first roll-over performed in that mode.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int IX_SEC = 0;
  localparam int IX_MIN = 2;
  localparam int IX_HR  = 4;
  localparam int IX_DOW = 6;
  localparam int IX_DOM = 7;
  localparam int IX_MON = 8;
  localparam int IX_YR  = 9;
  localparam int IX_CA  = 10;
  localparam int IX_CB  = 11;

  localparam int CB_FREEZE = 7;
  localparam int CB_BIN    = 2;
  localparam int CB_H24    = 1;

  localparam logic [7:0] CB_RESET = 8'h02;

  // stored byte -> numeric value (bin=1: plain binary, else two BCD digits)
  function automatic logic [6:0] fld_dec(input logic [7:0] v, input logic bin);
    logic [6:0] t;
    t = 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    return bin ? v[6:0] : t;
  endfunction

  // numeric value -> stored byte
  function automatic logic [7:0] fld_enc(input logic [6:0] n, input logic bin);
    logic [3:0] tens, ones;
    tens = 4'(n / 7'd10);
    ones = 4'(n % 7'd10);
    return bin ? {1'b0, n} : {tens, ones};
  endfunction
endpackage

// File: rtl/tod_uip_timer.sv
module tod_uip_timer #(
  parameter int UIP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  output logic busy,
  output logic commit
);
  localparam int CW = $clog2(UIP_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (tick && !hold) begin
      cnt_q <= CW'(UIP_CYC);
    end
  end

  assign busy   = (cnt_q != '0);
  assign commit = (cnt_q == CW'(1)) && !hold;
endmodule

// File: rtl/tod_step.sv
module tod_step
  import tod_pkg::*;
(
  input  logic [7:0] sec_i,
  input  logic [7:0] min_i,
  input  logic [7:0] hr_i,
  input  logic [7:0] dow_i,
  input  logic [7:0] dom_i,
  input  logic [7:0] mon_i,
  input  logic [7:0] yr_i,
  input  logic       bin,
  input  logic       h24,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic [7:0] dow_o,
  output logic [7:0] dom_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o
);
  logic [6:0] s, m, hv, h, dw, dm, mo, y, dim, h12;
  logic [6:0] sn, mn, hn, dwn, dmn, mon, yn;

  always_comb begin
    s  = fld_dec(sec_i, bin);
    m  = fld_dec(min_i, bin);
    dw = fld_dec(dow_i, bin);
    dm = fld_dec(dom_i, bin);
    mo = fld_dec(mon_i, bin);
    y  = fld_dec(yr_i, bin);
    // hour to 0..23
    hv = fld_dec(h24 ? hr_i : {1'b0, hr_i[6:0]}, bin);
    if (h24) h = hv;
    else     h = ((hv == 7'd12) ? 7'd0 : hv) + (hr_i[7] ? 7'd12 : 7'd0);

    case (mo)
      7'd2:                      dim = (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   dim = 7'd30;
      default:                   dim = 7'd31;
    endcase

    sn = s; mn = m; hn = h; dwn = dw; dmn = dm; mon = mo; yn = y;
    if (s >= 7'd59) begin
      sn = 7'd0;
      if (m >= 7'd59) begin
        mn = 7'd0;
        if (h >= 7'd23) begin
          hn  = 7'd0;
          dwn = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
          if (dm >= dim) begin
            dmn = 7'd1;
            if (mo >= 7'd12) begin
              mon = 7'd1;
              yn  = (y >= 7'd99) ? 7'd0 : y + 7'd1;
            end else begin
              mon = mo + 7'd1;
            end
          end else begin
            dmn = dm + 7'd1;
          end
        end else begin
          hn = h + 7'd1;
        end
      end else begin
        mn = m + 7'd1;
      end
    end else begin
      sn = s + 7'd1;
    end

    h12 = (hn % 7'd12 == 7'd0) ? 7'd12 : hn % 7'd12;
    if (h24) hr_o = fld_enc(hn, bin);
    else     hr_o = fld_enc(h12, bin) | {hn >= 7'd12, 7'b0};
    sec_o = fld_enc(sn, bin);
    min_o = fld_enc(mn, bin);
    dow_o = fld_enc(dwn, bin);
    dom_o = fld_enc(dmn, bin);
    mon_o = fld_enc(mon, bin);
    yr_o  = fld_enc(yn, bin);
  end
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int UIP_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_1hz,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             dat_we,
  input  logic [7:0]       dat_in,
  output logic [7:0]       rd_data,
  output logic             uip
);
  logic [IDX_W-1:0] idx_q;
  logic [7:0] sec_q, min_q, hr_q, dow_q, dom_q, mon_q, yr_q, cb_q;
  logic [6:0] ca_q;
  logic [7:0] sec_n, min_n, hr_n, dow_n, dom_n, mon_n, yr_n;
  logic [7:0] rd_mux;
  logic       set_mode, commit;

  assign set_mode = cb_q[CB_FREEZE];

  tod_uip_timer #(.UIP_CYC(UIP_CYC)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_1hz), .hold(set_mode),
    .busy(uip), .commit(commit)
  );

  tod_step u_step (
    .sec_i(sec_q), .min_i(min_q), .hr_i(hr_q), .dow_i(dow_q),
    .dom_i(dom_q), .mon_i(mon_q), .yr_i(yr_q),
    .bin(cb_q[CB_BIN]), .h24(cb_q[CB_H24]),
    .sec_o(sec_n), .min_o(min_n), .hr_o(hr_n), .dow_o(dow_n),
    .dom_o(dom_n), .mon_o(mon_n), .yr_o(yr_n)
  );

  always_comb begin
    case (idx_q)
      IDX_W'(IX_SEC): rd_mux = sec_q;
      IDX_W'(IX_MIN): rd_mux = min_q;
      IDX_W'(IX_HR):  rd_mux = hr_q;
      IDX_W'(IX_DOW): rd_mux = dow_q;
      IDX_W'(IX_DOM): rd_mux = dom_q;
      IDX_W'(IX_MON): rd_mux = mon_q;
      IDX_W'(IX_YR):  rd_mux = yr_q;
      IDX_W'(IX_CA):  rd_mux = {uip, ca_q};
      IDX_W'(IX_CB):  rd_mux = cb_q;
      default:        rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00;
      dow_q <= 8'h01; dom_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00;
      ca_q  <= 7'h00; cb_q <= CB_RESET;
      rd_data <= 8'h00;
    end else begin
      rd_data <= rd_mux;
      if (commit) begin
        sec_q <= sec_n; min_q <= min_n; hr_q <= hr_n; dow_q <= dow_n;
        dom_q <= dom_n; mon_q <= mon_n; yr_q <= yr_n;
      end
      if (dat_we) begin
        case (idx_q)
          IDX_W'(IX_SEC): sec_q <= dat_in;
          IDX_W'(IX_MIN): min_q <= dat_in;
          IDX_W'(IX_HR):  hr_q  <= dat_in;
          IDX_W'(IX_DOW): dow_q <= dat_in;
          IDX_W'(IX_DOM): dom_q <= dat_in;
          IDX_W'(IX_MON): mon_q <= dat_in;
          IDX_W'(IX_YR):  yr_q  <= dat_in;
          IDX_W'(IX_CA):  ca_q  <= dat_in[6:0];
          IDX_W'(IX_CB):  cb_q  <= dat_in;
          default: ;
        endcase
      end
      if (idx_we) idx_q <= idx_in;
    end
  end
endmodule

// File: rtl/tod_calendar_chk.sv
module tod_calendar_chk
  import tod_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int UIP_CYC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_1hz,
  input logic             uip,
  input logic             dat_we,
  input logic             commit,
  input logic             set_mode,
  input logic [7:0]       sec_q,
  input logic [IDX_W-1:0] idx_q,
  input logic [7:0]       rd_data
);
  int hi_run;

  always_ff @(posedge clk) begin
    if (rst)      hi_run <= 0;
    else if (uip) hi_run <= hi_run + 1;
    else          hi_run <= 0;
  end

  // R10
  uip_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(uip) |-> $past(tick_1hz));

  // R10
  uip_len_chk: assert property (@(posedge clk) disable iff (rst)
    hi_run <= UIP_CYC);

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(set_mode) && !$past(dat_we)) |-> $stable(sec_q));

  // R2
  sec_moves_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(commit) && !$past(dat_we)) |-> !$stable(sec_q));

  // R10
  uip_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(idx_q) == IDX_W'(IX_CA)) |-> (rd_data[7] == $past(uip)));
endmodule

bind tod_calendar tod_calendar_chk #(.IDX_W(IDX_W), .UIP_CYC(UIP_CYC)) u_chk (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .uip(uip), .dat_we(dat_we),
  .commit(commit), .set_mode(set_mode), .sec_q(sec_q), .idx_q(idx_q),
  .rd_data(rd_data)
);

// File: tb/test_tod_calendar.sv
module test_tod_calendar;
  localparam int WIN = 4;

  logic clk = 0, rst = 1, tick_1hz = 0, idx_we = 0, dat_we = 0;
  logic [3:0] idx_in = '0;
  logic [7:0] dat_in = '0;
  logic [7:0] rd_data;
  logic       uip;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  tod_calendar #(.IDX_W(4), .UIP_CYC(WIN)) i_tod_calendar (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .idx_we(idx_we), .idx_in(idx_in),
    .dat_we(dat_we), .dat_in(dat_in), .rd_data(rd_data), .uip(uip)
  );

  // ---------------- behavioural reference model ----------------
  int m[16];
  int mi, mcnt, rd_exp;
  bit muip;
  int mdays_tbl[12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};

  function automatic int fromc(int v, bit b);
    return b ? v : (v >> 4) * 10 + (v & 15);
  endfunction
  function automatic int toc(int n, bit b);
    return b ? n : ((n / 10) << 4) | (n % 10);
  endfunction
  function automatic bit mapped(int i);
    return i inside {0, 2, 4, 6, 7, 8, 9, 10, 11};
  endfunction

  function automatic int mread(int i);
    if (i == 10) return (muip ? 128 : 0) | m[10];
    if (mapped(i)) return m[i];
    return 0;
  endfunction

  task automatic madvance();
    bit b = m[11][2];
    bit h24 = m[11][1];
    int s = fromc(m[0], b), mn = fromc(m[2], b), hr, dw = fromc(m[6], b);
    int dm = fromc(m[7], b), mo = fromc(m[8], b), yr = fromc(m[9], b), lim;
    if (h24) hr = fromc(m[4], b);
    else begin
      hr = fromc(m[4] & 127, b) % 12;
      if (m[4] & 128) hr += 12;
    end
    s++;
    if (s == 60) begin
      s = 0; mn++;
      if (mn == 60) begin
        mn = 0; hr++;
        if (hr == 24) begin
          hr = 0; dw = dw % 7 + 1; dm++;
          lim = mdays_tbl[mo - 1];
          if (mo == 2 && yr % 4 == 0) lim = 29;
          if (dm > lim) begin
            dm = 1; mo++;
            if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
          end
        end
      end
    end
    m[0] = toc(s, b); m[2] = toc(mn, b); m[6] = toc(dw, b);
    m[7] = toc(dm, b); m[8] = toc(mo, b); m[9] = toc(yr, b);
    if (h24) m[4] = toc(hr, b);
    else m[4] = toc((hr + 11) % 12 + 1, b) | (hr >= 12 ? 128 : 0);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      foreach (m[k]) m[k] = 0;
      m[6] = 1; m[7] = 1; m[8] = 1; m[11] = 2;
      mi = 0; mcnt = 0; rd_exp = 0; muip = 0;
    end else begin
      bit cm;
      rd_exp = mread(mi);
      cm = (mcnt == 1) && !m[11][7];
      if (mcnt != 0) mcnt--;
      else if (tick_1hz && !m[11][7]) mcnt = WIN;
      if (cm) madvance();
      if (dat_we && mapped(mi)) m[mi] = (mi == 10) ? (dat_in & 127) : int'(dat_in);
      if (idx_we) mi = idx_in;
      muip = (mcnt != 0);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rd_data !== 8'(rd_exp)) begin
        errs++;
        $display("FAIL R1 rd_data actual=%h expected=%h", rd_data, rd_exp[7:0]);
      end
      checks++;
      if (uip !== muip) begin
        errs++;
        $display("FAIL R10 uip actual=%b expected=%b", uip, muip);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int i, int v);
    @(negedge clk); idx_we = 1; idx_in = 4'(i); dat_we = 0;
    @(negedge clk); idx_we = 0; dat_we = 1; dat_in = 8'(v);
    @(negedge clk); dat_we = 0;
  endtask

  task automatic rd(int i, output int v);
    @(negedge clk); idx_we = 1; idx_in = 4'(i);
    @(negedge clk); idx_we = 0;
    @(negedge clk); v = rd_data;
  endtask

  task automatic rchk(string tag, int i, int exp);
    int v;
    rd(i, v);
    chk(tag, v, exp);
  endtask

  task automatic do_tick();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    repeat (WIN + 2) @(negedge clk);
  endtask

  task automatic set_time(int b, int s, int mn, int h, int dw, int dm, int mo, int y);
    wr(11, b | 8'h80);
    wr(0, s); wr(2, mn); wr(4, h); wr(6, dw); wr(7, dm); wr(8, mo); wr(9, y);
    wr(11, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    chk("R12 uip", uip, 0);
    chk("R12 rd_data", rd_data, 0);
    rchk("R12 sec", 0, 0); rchk("R12 min", 2, 0); rchk("R12 hour", 4, 0);
    rchk("R12 dow", 6, 1); rchk("R12 dom", 7, 1); rchk("R12 month", 8, 1);
    rchk("R12 year", 9, 0); rchk("R12 ctlA", 10, 0); rchk("R12 ctlB", 11, 8'h02);

    // R1 mapped write, unmapped ignored
    wr(2, 8'h33); rchk("R1 minutes readback", 2, 8'h33);
    wr(1, 8'h55); rchk("R1 unmapped idx1", 1, 0);
    wr(12, 8'hAA); rchk("R1 unmapped idx12", 12, 0);

    // R2 R3 R5 R6 R7 R8: BCD 24h full roll-over
    set_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    do_tick();
    rchk("R2 sec wrap", 0, 0); rchk("R2 min wrap", 2, 0);
    rchk("R3 hour wrap", 4, 0); rchk("R5 dow wrap", 6, 1);
    rchk("R6 dom wrap", 7, 1); rchk("R7 month wrap", 8, 1);
    rchk("R7 year wrap", 9, 0);

    // R8 BCD digit carry
    wr(0, 8'h09); do_tick();
    rchk("R8 bcd sec 09->10", 0, 8'h10); rchk("R2 min unchanged", 2, 0);

    // R6 February
    set_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    do_tick();
    rchk("R6 feb28 nonleap dom", 7, 1); rchk("R6 feb28 nonleap mon", 8, 3);
    set_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    do_tick();
    rchk("R6 feb28 leap dom", 7, 8'h29); rchk("R6 feb28 leap mon", 8, 2);
    set_time(8'h02, 8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    do_tick();
    rchk("R6 feb29 leap dom", 7, 1); rchk("R6 feb29 leap mon", 8, 3);

    // R6 R8 binary mode month lengths
    set_time(8'h06, 59, 59, 23, 2, 30, 4, 5);
    do_tick();
    rchk("R6 apr30 dom", 7, 1); rchk("R6 apr30 mon", 8, 5);
    set_time(8'h06, 59, 59, 23, 2, 30, 5, 5);
    do_tick();
    rchk("R6 may30 dom", 7, 31); rchk("R6 may30 mon", 8, 5);
    wr(0, 9); do_tick();
    rchk("R8 binary sec 9->10", 0, 8'h0A);

    // R4 12-hour BCD
    set_time(8'h00, 8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h01, 8'h00);
    do_tick();
    rchk("R4 11AM->12PM", 4, 8'h92); rchk("R4 no day carry", 7, 8'h10);
    wr(0, 8'h59); wr(2, 8'h59); do_tick();
    rchk("R4 12PM->1PM", 4, 8'h81);
    wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h91); do_tick();
    rchk("R4 11PM->12AM", 4, 8'h12); rchk("R4 day carry", 7, 8'h11);
    wr(0, 8'h59); wr(2, 8'h59); do_tick();
    rchk("R4 12AM->1AM", 4, 8'h01);
    // R4 12-hour binary
    set_time(8'h04, 59, 59, 8'h8B, 1, 10, 1, 0);
    do_tick();
    rchk("R4 binary 11PM->12AM", 4, 8'h0C);

    // R9 freeze
    wr(11, 8'h82); wr(0, 8'h21);
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    chk("R9 uip stays low", uip, 0);
    repeat (WIN + 2) @(negedge clk);
    rchk("R9 sec frozen", 0, 8'h21);
    wr(11, 8'h02);

    // R10 read-only flag and window
    wr(10, 8'hFF); rchk("R10 ctlA bit7 ignored", 10, 8'h7F);
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    chk("R10 uip high", uip, 1);
    @(negedge clk);
    chk("R10 ctlA bit7 in window", rd_data, 8'hFF);
    repeat (WIN) @(negedge clk);
    chk("R10 uip low after window", uip, 0);
    rchk("R10 sec advanced", 0, 8'h22);

    // R11 no conversion
    wr(0, 8'h25); wr(11, 8'h06);
    rchk("R11 sec kept", 0, 8'h25);
    rchk("R11 ctlB", 11, 8'h06);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule